// File: doc/BRIEF.md
# Three-Press Sequence Door Lock

This block is a small clocked controller that releases a door latch when a two-button keypad delivers the presses B, then A, then B. Each cycle it samples a three-bit keypad code made of a press-valid flag and two button lines, all already synchronous to the clock. It drives a one-cycle release strobe and a four-bit press counter that a display decoder downstream turns into digits.

A wrong press does not drop back to zero at once. The controller moves onto a separate failure track that keeps counting presses in step with the correct track, up to the third press. An onlooker watching the display therefore cannot tell from the count when the code went wrong. Both outputs come from the registered state alone, so they change only at a rising clock edge.

Top module: `seq_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters its idle state; in the next cycle `press_cnt` is 0 and `unlock_pulse` is 0.
- R2: The keypad code `{key_vld, key_a, key_b}` means button A when it is 3'b110 and button B when it is 3'b101. Every other value, including 3'b111, 3'b100, 3'b011, 3'b001 and 3'b010, counts as no press and leaves the state unchanged.
- R3: In every state except the open state, a cycle with no press keeps the state, so `press_cnt` and `unlock_pulse` hold their values.
- R4: The presses B, A, B bring `press_cnt` to 1, 2 and 3 in turn. Each value appears in the cycle after the edge that samples its press. `unlock_pulse` is 1 in the same cycle that the count shows 3.
- R5: `unlock_pulse` stays high for exactly one cycle. On the next edge the controller returns to idle (`press_cnt` = 0) whatever the keypad code is.
- R6: If the first press is A, the count goes to 1. Any next press brings it to 2, and any third press brings it to 0. `unlock_pulse` stays 0 on this path.
- R7: If B is followed by a second B, the count goes to 2. Any next press brings it to 0, with no unlock.
- R8: If B, A is followed by A, the count goes to 0 and `unlock_pulse` stays 0.
- R9: From a count of 0 or 1, every valid press raises `press_cnt` by exactly one on the next edge. `press_cnt` never goes above 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| key_vld | input | 1 | Press-valid flag of the keypad code |
| key_a | input | 1 | Button A line of the keypad code |
| key_b | input | 1 | Button B line of the keypad code |
| unlock_pulse | output | 1 | One-cycle door release strobe |
| press_cnt | output | CNT_W (4) | Number of presses in the current attempt |

## Verification
The assertions assume that the keypad code is already synchronous and stable around each rising edge, and that one press takes exactly one cycle of a valid code. A button held for several cycles would count as several presses. The bench drives every code on a falling edge and holds it for one full cycle. Between presses it inserts idle cycles or deliberately malformed codes, so the properties on holding, incrementing and the single-cycle strobe all see traffic that fits these assumptions.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'b000,
        ST_OK1  = 3'b001,
        ST_OK2  = 3'b010,
        ST_OPEN = 3'b011,
        ST_BAD1 = 3'b100,
        ST_BAD2 = 3'b101
    } lock_state_e;

    typedef enum logic [1:0] {
        KEY_NONE = 2'd0,
        KEY_A    = 2'd1,
        KEY_B    = 2'd2
    } key_e;

    typedef struct packed {
        logic       vld;
        logic       a;
        logic       b;
    } key_code_t;

    localparam logic [2:0] CODE_A = 3'b110;
    localparam logic [2:0] CODE_B = 3'b101;

    typedef struct packed {
        logic       release_door;
        logic [1:0] presses;
    } lock_view_t;

    function automatic key_e classify(input key_code_t c);
        if (c == CODE_A)      return KEY_A;
        else if (c == CODE_B) return KEY_B;
        else                  return KEY_NONE;
    endfunction

    function automatic lock_view_t view_of(input lock_state_e s);
        lock_view_t v;
        v = '0;
        case (s)
            ST_OK1, ST_BAD1: v.presses = 2'd1;
            ST_OK2, ST_BAD2: v.presses = 2'd2;
            ST_OPEN: begin
                v.presses      = 2'd3;
                v.release_door = 1'b1;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lock_key_decode.sv
module lock_key_decode
    import lock_pkg::*;
(
    input  logic key_vld,
    input  logic key_a,
    input  logic key_b,
    output key_e key
);
    key_code_t code;

    always_comb begin
        code.vld = key_vld;
        code.a   = key_a;
        code.b   = key_b;
        key      = classify(code);
    end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
    import lock_pkg::*;
(
    input  lock_state_e cur,
    input  key_e        key,
    output lock_state_e nxt
);
    always_comb begin
        nxt = cur;
        case (cur)
            ST_IDLE: begin
                if (key == KEY_B)      nxt = ST_OK1;
                else if (key == KEY_A) nxt = ST_BAD1;
            end
            ST_OK1: begin
                if (key == KEY_A)      nxt = ST_OK2;
                else if (key == KEY_B) nxt = ST_BAD2;
            end
            ST_OK2: begin
                if (key == KEY_B)      nxt = ST_OPEN;
                else if (key == KEY_A) nxt = ST_IDLE;
            end
            ST_OPEN: nxt = ST_IDLE;
            ST_BAD1: begin
                if (key != KEY_NONE)   nxt = ST_BAD2;
            end
            ST_BAD2: begin
                if (key != KEY_NONE)   nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lock_state_e nxt,
    output lock_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end
endmodule

// File: rtl/lock_out_map.sv
module lock_out_map
    import lock_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  lock_state_e      cur,
    output logic             unlock_pulse,
    output logic [CNT_W-1:0] press_cnt
);
    lock_view_t view;

    always_comb begin
        view         = view_of(cur);
        unlock_pulse = view.release_door;
        press_cnt    = CNT_W'(view.presses);
    end
endmodule

// File: rtl/seq_lock.sv
module seq_lock
    import lock_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_vld,
    input  logic             key_a,
    input  logic             key_b,
    output logic             unlock_pulse,
    output logic [CNT_W-1:0] press_cnt
);
    key_e        key;
    lock_state_e cur;
    lock_state_e nxt;

    lock_key_decode u_dec (
        .key_vld (key_vld),
        .key_a   (key_a),
        .key_b   (key_b),
        .key     (key)
    );

    lock_next_state u_ns (
        .cur (cur),
        .key (key),
        .nxt (nxt)
    );

    lock_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    lock_out_map #(.CNT_W(CNT_W)) u_out (
        .cur          (cur),
        .unlock_pulse (unlock_pulse),
        .press_cnt    (press_cnt)
    );
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             key_vld,
    input logic             key_a,
    input logic             key_b,
    input logic             unlock_pulse,
    input logic [CNT_W-1:0] press_cnt
);
    logic [2:0] code;
    logic       pressed;
    logic       is_b;

    assign code    = {key_vld, key_a, key_b};
    assign is_b    = (code == 3'b101);
    assign pressed = (code == 3'b110) || is_b;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (press_cnt == '0 && !unlock_pulse));

    // R3
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!pressed && !unlock_pulse) |=> $stable(press_cnt));

    // R4
    a_r4_open_shows_three: assert property (@(posedge clk) disable iff (rst)
        unlock_pulse |-> press_cnt == CNT_W'(3));

    // R4
    a_r4_open_after_b: assert property (@(posedge clk) disable iff (rst)
        ($past(press_cnt) == CNT_W'(2) && $past(is_b) && !$past(rst)) || !unlock_pulse);

    // R5
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        unlock_pulse |=> (!unlock_pulse && press_cnt == '0));

    // R9
    a_r9_step_up: assert property (@(posedge clk) disable iff (rst)
        (pressed && press_cnt < CNT_W'(2)) |=> press_cnt == $past(press_cnt) + CNT_W'(1));

    // R9
    a_r9_ceiling: assert property (@(posedge clk) disable iff (rst)
        press_cnt <= CNT_W'(3));
endmodule

bind seq_lock lock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .key_vld      (key_vld),
    .key_a        (key_a),
    .key_b        (key_b),
    .unlock_pulse (unlock_pulse),
    .press_cnt    (press_cnt)
);

// File: tb/sim_seq_lock.sv
`timescale 1ns/1ps
module sim_seq_lock;
    localparam int CNT_W = 4;
    localparam logic [2:0] NK = 3'b000;
    localparam logic [2:0] KA = 3'b110;
    localparam logic [2:0] KB = 3'b101;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             key_vld = 1'b0;
    logic             key_a = 1'b0;
    logic             key_b = 1'b0;
    logic             unlock_pulse;
    logic [CNT_W-1:0] press_cnt;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    seq_lock #(.CNT_W(CNT_W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .key_vld      (key_vld),
        .key_a        (key_a),
        .key_b        (key_b),
        .unlock_pulse (unlock_pulse),
        .press_cnt    (press_cnt)
    );

    task automatic chk(input string tag, input int exp_cnt, input logic exp_u);
        total++;
        if (int'(press_cnt) != exp_cnt || unlock_pulse !== exp_u) begin
            bad++;
            $display("FAIL %s: cnt=%0d u=%0b expected cnt=%0d u=%0b",
                     tag, press_cnt, unlock_pulse, exp_cnt, exp_u);
        end
    endtask

    // drive a code for one cycle, return just after the edge that samples it
    task automatic apply(input logic [2:0] c);
        @(negedge clk);
        {key_vld, key_a, key_b} = c;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {key_vld, key_a, key_b} = KB;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        {key_vld, key_a, key_b} = NK;
    endtask

    task automatic t_reset();
        apply(KB);
        do_reset();
        chk("R1 reset clears", 0, 1'b0);
    endtask

    task automatic t_good_sequence();
        do_reset();
        apply(KB); chk("R4 first B", 1, 1'b0);
        apply(NK); chk("R3 hold after B", 1, 1'b0);
        apply(KA); chk("R4 then A", 2, 1'b0);
        apply(NK); chk("R3 hold after A", 2, 1'b0);
        apply(KB); chk("R4 final B opens", 3, 1'b1);
        apply(NK); chk("R5 back to idle", 0, 1'b0);
    endtask

    task automatic t_open_ignores_key();
        do_reset();
        apply(KB); apply(KA); apply(KB);
        chk("R4 open", 3, 1'b1);
        apply(KB); chk("R5 key during open ignored", 0, 1'b0);
        apply(KB); chk("R9 fresh press counts", 1, 1'b0);
    endtask

    task automatic t_fail_first_a();
        do_reset();
        apply(KA); chk("R6 wrong first", 1, 1'b0);
        apply(NK); chk("R3 hold on fail track", 1, 1'b0);
        apply(KB); chk("R6 second press", 2, 1'b0);
        apply(NK); chk("R3 hold on fail track 2", 2, 1'b0);
        apply(KB); chk("R6 third press returns", 0, 1'b0);
    endtask

    task automatic t_fail_double_b();
        do_reset();
        apply(KB); apply(KB);
        chk("R7 second B", 2, 1'b0);
        apply(KA); chk("R7 third press returns", 0, 1'b0);
    endtask

    task automatic t_abort_on_a();
        do_reset();
        apply(KB); apply(KA); apply(KA);
        chk("R8 B A A", 0, 1'b0);
    endtask

    task automatic t_bad_codes();
        do_reset();
        apply(3'b111); chk("R2 code 111 ignored", 0, 1'b0);
        apply(3'b100); chk("R2 code 100 ignored", 0, 1'b0);
        apply(3'b011); chk("R2 code 011 ignored", 0, 1'b0);
        apply(3'b010); chk("R2 code 010 ignored", 0, 1'b0);
        apply(3'b001); chk("R2 code 001 ignored", 0, 1'b0);
        apply(KB);
        apply(3'b111); chk("R2 111 after B ignored", 1, 1'b0);
        apply(3'b010); chk("R2 010 after B ignored", 1, 1'b0);
        apply(KA);     chk("R2 A still accepted", 2, 1'b0);
        apply(3'b001); chk("R2 001 after BA ignored", 2, 1'b0);
        apply(KB);     chk("R2 B still opens", 3, 1'b1);
    endtask

    initial begin
        t_reset();
        t_good_sequence();
        t_open_ignores_key();
        t_fail_first_a();
        t_fail_double_b();
        t_abort_on_a();
        t_bad_codes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule